// File: doc/BRIEF.md
# Dual-Port Collision Busy Arbiter

This block is a true dual-port memory with collision arbitration in front of it. Each side (left and right) has its own enable, write strobe, address, write data and registered read data. Both sides read and write the array at the same time and do not slow each other down. A busy flag is raised only when both sides are enabled on the same word in the same cycle. In that case one side wins and the other side is flagged busy. If the flagged side is writing, its write strobe is removed inside the block, so it cannot change the array.

A mode input selects how the busy logic works. In arbitrating (master) mode the block decides the winner and drives the busy outputs. The decision uses only enables and addresses; a read collides just as a write does. In follower (slave) mode the block makes no decision of its own. The busy outputs stay low. Each side then takes an active-low inhibit input whose only effect is to block that side's writes, so several arrays can follow one arbiter's verdict. Busy is a registered flag, so an inhibit that follows it cannot glitch within a write cycle.

Top module: `dpb_arbiter_top`

## Requirements
- R1: With `ms_sel`=1, a busy output is raised only after a cycle in which both enables were high and both addresses were equal. Accesses to different addresses raise no busy, and both sides' writes land.
- R2: At most one of `l_busy_o` and `r_busy_o` is high in any cycle.
- R3: In master mode, a write from the side that loses a collision does not change the array. The winning side's write does take effect.
- R4: Reads and writes are treated alike. A read/read collision on one address raises busy exactly as a write collision does.
- R5: When both sides arrive at a shared address in the same cycle, and neither side was on that address in the previous cycle, the left side wins and `r_busy_o` is raised.
- R6: If only one side was enabled on the colliding address in the previous cycle, that side wins. While a collision lasts unchanged, the earlier winner keeps priority.
- R7: Busy is registered. It is visible in the cycle after the colliding edge, stays high while the collision persists, and drops in the cycle after the winner changes its enable or address.
- R8: With `ms_sel`=0, both busy outputs stay low and no write is blocked by arbitration. A same-address write from the right side lands even while the left side reads that word.
- R9: With `ms_sel`=0, a low `l_inhibit_n`/`r_inhibit_n` blocks every write from that side, and a high one allows normal writes.
- R10: Read data appears one cycle after an enabled read. It returns the word as it was before any write at that same edge (read-first).
- R11: After reset, both busy outputs and both read data outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ms_sel | input | 1 | 1 = arbitrating (master), 0 = follower (slave) |
| l_en | input | 1 | Left side enable |
| l_we | input | 1 | Left side write strobe |
| l_addr | input | ADDR_W | Left side address |
| l_wdata | input | DATA_W | Left side write data |
| l_rdata | output | DATA_W | Left side registered read data |
| l_busy_o | output | 1 | Left side lost a collision (master mode) |
| l_inhibit_n | input | 1 | Left side write inhibit, active low (slave mode) |
| r_en | input | 1 | Right side enable |
| r_we | input | 1 | Right side write strobe |
| r_addr | input | ADDR_W | Right side address |
| r_wdata | input | DATA_W | Right side write data |
| r_rdata | output | DATA_W | Right side registered read data |
| r_busy_o | output | 1 | Right side lost a collision (master mode) |
| r_inhibit_n | input | 1 | Right side write inhibit, active low (slave mode) |

## Verification
The hardest case to reach from the ports is priority carried over from an earlier cycle. One side must already sit on an address when the other side arrives, and the collision must then be held for several cycles before the winner moves away. The directed stimulus places the right side alone on a word for one cycle, then has both sides write that word for two cycles. It checks that the left side stays flagged and that its data never lands. A second sequence has the left side move to a neighbouring address while the right side stays put, which shows the release timing. Follower-mode collisions also need care: the stimulus switches the mode input and confirms that a same-address write goes through with no flag raised.

// File: rtl/dpb_pkg.sv
package dpb_pkg;
  localparam int NUM_SIDES = 2;
  typedef enum logic {SIDE_L = 1'b0, SIDE_R = 1'b1} side_e;
endpackage

// File: rtl/dpb_collide.sv
module dpb_collide #(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ms,
  input  logic              l_en,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic              r_en,
  input  logic [ADDR_W-1:0] r_addr,
  output logic [1:0]        lose,
  output logic [1:0]        busy_q
);
  import dpb_pkg::*;

  logic              l_en_q, r_en_q;
  logic [ADDR_W-1:0] l_addr_q, r_addr_q;
  logic              coll_q, win_r_q;
  logic              coll, l_hold, r_hold, win_r;

  always_comb begin
    coll   = l_en && r_en && (l_addr == r_addr);
    l_hold = l_en && l_en_q && (l_addr_q == l_addr);
    r_hold = r_en && r_en_q && (r_addr_q == r_addr);
    if (l_hold && r_hold && coll_q) win_r = win_r_q;
    else                            win_r = r_hold && !l_hold;
    lose[SIDE_L] = ms && coll && win_r;
    lose[SIDE_R] = ms && coll && !win_r;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      l_en_q   <= 1'b0;
      r_en_q   <= 1'b0;
      l_addr_q <= '0;
      r_addr_q <= '0;
      coll_q   <= 1'b0;
      win_r_q  <= 1'b0;
      busy_q   <= 2'b00;
    end else begin
      l_en_q   <= l_en;
      r_en_q   <= r_en;
      l_addr_q <= l_addr;
      r_addr_q <= r_addr;
      coll_q   <= coll;
      win_r_q  <= win_r;
      busy_q   <= lose;
    end
  end

  // R5: simultaneous fresh arrival goes to the left side
  assert_tie_left_R5: assert property (@(posedge clk) disable iff (rst)
    (ms && coll && !l_hold && !r_hold) |=> (busy_q[SIDE_R] && !busy_q[SIDE_L]));

  // R6: a side already on the address keeps it
  assert_hold_right_R6: assert property (@(posedge clk) disable iff (rst)
    (ms && coll && r_hold && !l_hold) |=> busy_q[SIDE_L]);

  // R7: busy only rises after a collision cycle
  assert_busy_reg_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_q[SIDE_R]) |-> $past(coll));
endmodule

// File: rtl/dpb_wgate.sv
module dpb_wgate (
  input  logic clk,
  input  logic rst,
  input  logic ms,
  input  logic en,
  input  logic we,
  input  logic lose,
  input  logic inhibit_n,
  output logic we_eff
);
  always_comb begin
    if (ms) we_eff = en && we && !lose;
    else    we_eff = en && we && inhibit_n;
  end

  // R3: a losing side never writes in master mode
  assert_loser_blocked_R3: assert property (@(posedge clk) disable iff (rst)
    (ms && lose) |-> !we_eff);

  // R9: follower inhibit blocks the write
  assert_slave_inhibit_R9: assert property (@(posedge clk) disable iff (rst)
    (!ms && !inhibit_n) |-> !we_eff);
endmodule

// File: rtl/dpb_mem.sv
module dpb_mem #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              a_en,
  input  logic              a_we,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [DATA_W-1:0] a_wdata,
  output logic [DATA_W-1:0] a_rdata,
  input  logic              b_en,
  input  logic              b_we,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic [DATA_W-1:0] b_wdata,
  output logic [DATA_W-1:0] b_rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // side b is applied first so side a prevails on a shared word
  always_ff @(posedge clk) begin
    if (b_we) mem[b_addr] <= b_wdata;
    if (a_we) mem[a_addr] <= a_wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      a_rdata <= '0;
      b_rdata <= '0;
    end else begin
      if (a_en) a_rdata <= mem[a_addr];
      if (b_en) b_rdata <= mem[b_addr];
    end
  end
endmodule

// File: rtl/dpb_arbiter_top.sv
module dpb_arbiter_top #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ms_sel,
  input  logic              l_en,
  input  logic              l_we,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [DATA_W-1:0] l_wdata,
  output logic [DATA_W-1:0] l_rdata,
  output logic              l_busy_o,
  input  logic              l_inhibit_n,
  input  logic              r_en,
  input  logic              r_we,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic [DATA_W-1:0] r_wdata,
  output logic [DATA_W-1:0] r_rdata,
  output logic              r_busy_o,
  input  logic              r_inhibit_n
);
  import dpb_pkg::*;

  logic [NUM_SIDES-1:0] lose, busy_q, en_v, we_v, inh_v, we_eff;

  assign en_v  = {r_en, l_en};
  assign we_v  = {r_we, l_we};
  assign inh_v = {r_inhibit_n, l_inhibit_n};

  dpb_collide #(.ADDR_W(ADDR_W)) u_collide (
    .clk(clk), .rst(rst), .ms(ms_sel),
    .l_en(l_en), .l_addr(l_addr), .r_en(r_en), .r_addr(r_addr),
    .lose(lose), .busy_q(busy_q)
  );

  for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
    dpb_wgate u_wgate (
      .clk(clk), .rst(rst), .ms(ms_sel), .en(en_v[s]), .we(we_v[s]),
      .lose(lose[s]), .inhibit_n(inh_v[s]), .we_eff(we_eff[s])
    );
  end

  dpb_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk(clk), .rst(rst),
    .a_en(l_en), .a_we(we_eff[SIDE_L]), .a_addr(l_addr), .a_wdata(l_wdata), .a_rdata(l_rdata),
    .b_en(r_en), .b_we(we_eff[SIDE_R]), .b_addr(r_addr), .b_wdata(r_wdata), .b_rdata(r_rdata)
  );

  assign l_busy_o = busy_q[SIDE_L];
  assign r_busy_o = busy_q[SIDE_R];

  // R2: never both flagged
  assert_one_busy_R2: assert property (@(posedge clk) disable iff (rst)
    !(l_busy_o && r_busy_o));

  // R1: busy needs a same-address, both-enabled cycle before it
  assert_busy_cause_R1: assert property (@(posedge clk) disable iff (rst)
    (l_busy_o || r_busy_o) |-> $past(l_en && r_en && (l_addr == r_addr)));

  // R8: follower mode keeps busy low
  assert_slave_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    !ms_sel |=> (!l_busy_o && !r_busy_o));
endmodule

// File: tb/tb_dpb_arbiter_top.sv
module tb_dpb_arbiter_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 10;
  localparam int DW = 9;

  logic clk = 1'b0, rst = 1'b1, ms_sel = 1'b1;
  logic l_en = 0, l_we = 0, r_en = 0, r_we = 0;
  logic l_inhibit_n = 1, r_inhibit_n = 1;
  logic [AW-1:0] l_addr = '0, r_addr = '0;
  logic [DW-1:0] l_wdata = '0, r_wdata = '0;
  logic [DW-1:0] l_rdata, r_rdata;
  logic l_busy_o, r_busy_o;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dpb_arbiter_top #(.ADDR_W(AW), .DATA_W(DW)) dut (
    .clk(clk), .rst(rst), .ms_sel(ms_sel),
    .l_en(l_en), .l_we(l_we), .l_addr(l_addr), .l_wdata(l_wdata),
    .l_rdata(l_rdata), .l_busy_o(l_busy_o), .l_inhibit_n(l_inhibit_n),
    .r_en(r_en), .r_we(r_we), .r_addr(r_addr), .r_wdata(r_wdata),
    .r_rdata(r_rdata), .r_busy_o(r_busy_o), .r_inhibit_n(r_inhibit_n)
  );

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // caller sits at a negedge; returns at the next negedge
  task automatic cyc(input bit le, input bit lw, input logic [AW-1:0] la, input logic [DW-1:0] ld,
                     input bit re, input bit rw, input logic [AW-1:0] ra, input logic [DW-1:0] rd);
    l_en = le; l_we = lw; l_addr = la; l_wdata = ld;
    r_en = re; r_we = rw; r_addr = ra; r_wdata = rd;
    @(negedge clk);
  endtask

  task automatic idle();
    cyc(0, 0, '0, '0, 0, 0, '0, '0);
  endtask

  task automatic busy_is(input bit lb, input bit rb, input string tag);
    chk(l_busy_o, lb, {tag, " l_busy"});
    chk(r_busy_o, rb, {tag, " r_busy"});
  endtask

  task automatic read_l(input logic [AW-1:0] a, input int exp, input string tag);
    cyc(1, 0, a, '0, 0, 0, '0, '0);
    chk(l_rdata, exp, tag);
  endtask

  task automatic test_reset();
    busy_is(0, 0, "R11 reset");
    chk(l_rdata, 0, "R11 l_rdata reset");
    chk(r_rdata, 0, "R11 r_rdata reset");
  endtask

  task automatic test_diff_addr();
    cyc(1, 1, 10'h010, 9'h005, 1, 1, 10'h020, 9'h007);
    busy_is(0, 0, "R1 distinct writes");
    cyc(1, 0, 10'h020, '0, 1, 0, 10'h010, '0);
    busy_is(0, 0, "R1 distinct reads");
    chk(l_rdata, 9'h007, "R1 left sees right write");
    chk(r_rdata, 9'h005, "R10 right sees left write");
    idle();
  endtask

  task automatic test_rw_collision();
    cyc(1, 1, 10'h030, 9'h011, 0, 0, '0, '0);
    idle();
    cyc(1, 0, 10'h030, '0, 1, 1, 10'h030, 9'h1AA);
    busy_is(0, 1, "R5 read/write tie");
    chk(l_rdata, 9'h011, "R10 read-first on collision");
    idle();
    busy_is(0, 0, "R7 release after idle");
    read_l(10'h030, 9'h011, "R3 loser write blocked");
    idle();
  endtask

  task automatic test_ww_collision();
    cyc(1, 1, 10'h040, 9'h0A5, 1, 1, 10'h040, 9'h15A);
    busy_is(0, 1, "R5 write/write tie");
    idle();
    read_l(10'h040, 9'h0A5, "R3 winner write lands");
    idle();
  endtask

  task automatic test_rr_collision();
    cyc(1, 0, 10'h050, '0, 1, 0, 10'h050, '0);
    busy_is(0, 1, "R4 read/read collision");
    idle();
  endtask

  task automatic test_hold_priority();
    cyc(0, 0, '0, '0, 1, 0, 10'h060, '0);
    busy_is(0, 0, "R6 right alone");
    cyc(1, 1, 10'h060, 9'h0F0, 1, 1, 10'h060, 9'h123);
    busy_is(1, 0, "R6 holder wins");
    cyc(1, 1, 10'h060, 9'h0F0, 1, 1, 10'h060, 9'h123);
    busy_is(1, 0, "R7 busy persists");
    idle();
    read_l(10'h060, 9'h123, "R6 left write blocked");
    idle();
  endtask

  task automatic test_release();
    cyc(1, 0, 10'h070, '0, 0, 0, '0, '0);
    cyc(1, 0, 10'h070, '0, 1, 0, 10'h070, '0);
    busy_is(0, 1, "R6 left holder wins");
    cyc(1, 0, 10'h070, '0, 1, 0, 10'h070, '0);
    busy_is(0, 1, "R7 held collision");
    cyc(1, 0, 10'h071, '0, 1, 0, 10'h070, '0);
    busy_is(0, 0, "R7 release on winner move");
    idle();
  endtask

  task automatic test_slave();
    cyc(1, 1, 10'h090, 9'h033, 0, 0, '0, '0);
    idle();
    ms_sel = 1'b0;
    r_inhibit_n = 1'b0;
    cyc(1, 1, 10'h080, 9'h077, 1, 1, 10'h090, 9'h066);
    busy_is(0, 0, "R8 slave busy low");
    r_inhibit_n = 1'b1;
    idle();
    read_l(10'h080, 9'h077, "R9 inhibit high allows");
    read_l(10'h090, 9'h033, "R9 inhibit low blocks");
    cyc(1, 0, 10'h080, '0, 1, 1, 10'h080, 9'h1FF);
    busy_is(0, 0, "R8 slave collision no busy");
    idle();
    read_l(10'h080, 9'h1FF, "R8 no arbitration gating");
    l_inhibit_n = 1'b0;
    cyc(1, 1, 10'h080, 9'h001, 0, 0, '0, '0);
    l_inhibit_n = 1'b1;
    read_l(10'h080, 9'h1FF, "R9 left inhibit blocks");
    ms_sel = 1'b1;
    idle();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    test_reset();
    test_diff_addr();
    test_rw_collision();
    test_ww_collision();
    test_rr_collision();
    test_hold_priority();
    test_release();
    test_slave();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule